// File: doc/BRIEF.md
# DRAM Open-Page Hit Limiter

This block sits beside the command path of one DRAM channel. For every column access it decides whether the access should carry auto-precharge, which closes the row, or should leave the row open for a later access to the same row. Each bank has its own open-row record. A programmable 2-bit code sets how many consecutive page hits one opened row may serve before it must be closed.

A one-entry lookahead input reports whether the next queued access goes to the same bank and row. When no such follow-on hit is waiting, or the row has used up its hit budget, the current access closes the row itself. No separate precharge command is ever issued for this purpose. An access to a bank that holds a different open row raises a conflict flag, so the scheduler can precharge before it proceeds. A channel-enable bit blocks all processing while it is low and clears the tracking state.

The decision outputs are combinational from the presented access and the registered per-bank state. The bank state updates on the clock edge that accepts the access.

Top module: `page_hit_limiter`

## Requirements
- R1: The hit budget per opened row is decoded from `hit_code`: 2'b00 gives 0 hits, 2'b01 gives 1, 2'b10 gives 3 and 2'b11 gives 7. With `next_same`=1 held, a row opened by a miss is closed (`autopre`=1) on its (budget+1)-th access, so code 2'b11 allows at most 8 accesses to one row.
- R2: With `hit_code`=2'b00, every accepted access has `autopre`=1.
- R3: An accepted access with `next_same`=0 has `autopre`=1.
- R4: After an access with `autopre`=1, its bank is closed. The next access to that bank, to any row, has `conflict`=0 and starts a fresh hit count.
- R5: An accepted access to a bank whose open row differs from `acc_row` has `conflict`=1. That access then opens the new row with a hit count of zero.
- R6: Each bank keeps its own open flag, row and hit count. Accesses to one bank do not change another bank's state.
- R7: While `chan_en`=0, a valid access gives `blocked`=1, `autopre`=0 and `conflict`=0. `blocked` is 0 whenever `acc_valid`=0 or `chan_en`=1.
- R8: Any cycle with `chan_en`=0 closes all banks on its clock edge, so after re-enable no access sees a conflict until a row is opened again.
- R9: A cycle with `acc_valid`=0 leaves all bank state unchanged. After reset all banks are closed and all outputs are 0 when no access is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; 0 blocks accesses and clears state |
| hit_code | input | 2 | Encoded page-hit budget (0, 1, 3 or 7 hits) |
| acc_valid | input | 1 | Column access presented this cycle |
| acc_bank | input | 3 | Bank of the access |
| acc_row | input | 14 | Row of the access |
| next_same | input | 1 | Next queued access targets the same bank and row |
| autopre | output | 1 | Issue this access with auto-precharge |
| conflict | output | 1 | Bank holds a different open row; precharge needed first |
| blocked | output | 1 | Access refused because the channel is disabled |

## Verification
On every cycle the assertions check the rules that depend on one cycle only. Code 00 and a missing lookahead must force auto-precharge. A disabled channel must block with the other flags low. Blocked and conflict must never appear together. Every bank must be closed after a disabled cycle, and a closed bank must hold no hit count. The budget sequences that take several cycles (closing on the 2nd, 4th or 8th access), the independence of the banks, the restart after a conflict and the state kept across idle cycles can only be shown by the bench. It drives directed sequences and a long random mix, and compares each access against a reference model.

// File: rtl/hl_pkg.sv
package hl_pkg;
   localparam int MAX_HITS = 7;
   localparam int CNT_W    = $clog2(MAX_HITS + 1);

   typedef enum logic [1:0] {
      THR_NONE  = 2'b00,
      THR_ONE   = 2'b01,
      THR_THREE = 2'b10,
      THR_SEVEN = 2'b11
   } thr_code_e;

   function automatic logic [CNT_W-1:0] budget_of(input logic [1:0] code);
      case (thr_code_e'(code))
         THR_NONE:  budget_of = CNT_W'(0);
         THR_ONE:   budget_of = CNT_W'(1);
         THR_THREE: budget_of = CNT_W'(3);
         default:   budget_of = CNT_W'(7);
      endcase
   endfunction
endpackage

// File: rtl/hl_bank_state.sv
module hl_bank_state #(
   parameter int ROW_W = 14,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic             wr_open,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [CNT_W-1:0] wr_cnt,
   output logic             open_q,
   output logic [ROW_W-1:0] row_q,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (wr_en) begin
         open_q <= wr_open;
         row_q  <= wr_row;
         cnt_q  <= wr_open ? wr_cnt : '0;
      end
   end

   // R8: a disabled cycle leaves the bank closed
   assert_clear_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!open_q && cnt_q == '0));

   // R4: a closed bank carries no hit count
   assert_closed_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !open_q |-> cnt_q == '0);
endmodule

// File: rtl/hl_decide.sv
module hl_decide
   import hl_pkg::*;
#(
   parameter int ROW_W      = 14,
   parameter bit SHIFT_DECODE = 1'b0
) (
   input  logic [1:0]       hit_code,
   input  logic             bank_open,
   input  logic [ROW_W-1:0] bank_row,
   input  logic [CNT_W-1:0] bank_cnt,
   input  logic [ROW_W-1:0] acc_row,
   input  logic             next_same,
   output logic             is_conflict,
   output logic             close_now,
   output logic [CNT_W-1:0] used_cnt
);
   logic [CNT_W-1:0] budget;
   logic             is_hit;

   generate
      if (SHIFT_DECODE) begin : g_shift
         assign budget = CNT_W'((1 << hit_code) - 1);
      end else begin : g_table
         assign budget = budget_of(hit_code);
      end
   endgenerate

   always_comb begin
      is_hit      = bank_open && (bank_row == acc_row);
      is_conflict = bank_open && (bank_row != acc_row);
      used_cnt    = is_hit ? bank_cnt + CNT_W'(1) : '0;
      close_now   = !next_same || (used_cnt >= budget);
   end
endmodule

// File: rtl/page_hit_limiter.sv
module page_hit_limiter
   import hl_pkg::*;
#(
   parameter int NBANK        = 8,
   parameter int ROW_W        = 14,
   parameter bit SHIFT_DECODE = 1'b0,
   localparam int BANK_W      = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic [1:0]        hit_code,
   input  logic              acc_valid,
   input  logic [BANK_W-1:0] acc_bank,
   input  logic [ROW_W-1:0]  acc_row,
   input  logic              next_same,
   output logic              autopre,
   output logic              conflict,
   output logic              blocked
);
   generate
      if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
         $error("NBANK must be a power of two of at least 2");
      end
      if (ROW_W < 1) begin : g_bad_row
         $error("ROW_W must be positive");
      end
   endgenerate

   logic             accept;
   logic             sel_open;
   logic [ROW_W-1:0] sel_row;
   logic [CNT_W-1:0] sel_cnt;
   logic             dec_conflict;
   logic             dec_close;
   logic [CNT_W-1:0] dec_used;

   logic [NBANK-1:0] b_open;
   logic [ROW_W-1:0] b_row [NBANK];
   logic [CNT_W-1:0] b_cnt [NBANK];

   assign accept = acc_valid && chan_en;

   genvar gi;
   generate
      for (gi = 0; gi < NBANK; gi++) begin : g_bank
         hl_bank_state #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (!chan_en),
            .wr_en   (accept && (acc_bank == BANK_W'(gi))),
            .wr_open (!dec_close),
            .wr_row  (acc_row),
            .wr_cnt  (dec_used),
            .open_q  (b_open[gi]),
            .row_q   (b_row[gi]),
            .cnt_q   (b_cnt[gi])
         );
      end
   endgenerate

   always_comb begin
      sel_open = b_open[acc_bank];
      sel_row  = b_row[acc_bank];
      sel_cnt  = b_cnt[acc_bank];
   end

   hl_decide #(.ROW_W(ROW_W), .SHIFT_DECODE(SHIFT_DECODE)) u_decide (
      .hit_code    (hit_code),
      .bank_open   (sel_open),
      .bank_row    (sel_row),
      .bank_cnt    (sel_cnt),
      .acc_row     (acc_row),
      .next_same   (next_same),
      .is_conflict (dec_conflict),
      .close_now   (dec_close),
      .used_cnt    (dec_used)
   );

   assign autopre  = accept && dec_close;
   assign conflict = accept && dec_conflict;
   assign blocked  = acc_valid && !chan_en;

   // R2: zero budget closes every accepted access
   assert_code0_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && chan_en && hit_code == 2'b00) |-> autopre);

   // R3: no follow-on hit closes the row
   assert_no_lookahead_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && chan_en && !next_same) |-> autopre);

   // R7: a disabled channel blocks with other flags low
   assert_disabled_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !chan_en) |-> (blocked && !autopre && !conflict));

   // R5: conflict and blocked never together
   assert_conflict_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({blocked, conflict}));

   // R8: after a disabled cycle no bank is open
   assert_all_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> (b_open == '0));
endmodule

// File: tb/tb_page_hit_limiter.sv
module tb_page_hit_limiter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        chan_en;
   logic [1:0]  hit_code;
   logic        acc_valid;
   logic [2:0]  acc_bank;
   logic [13:0] acc_row;
   logic        next_same;
   logic        autopre, conflict, blocked;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   bit          m_open [8];
   logic [13:0] m_row  [8];
   int          m_cnt  [8];

   always #4 clk = ~clk;

   page_hit_limiter dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .hit_code(hit_code),
      .acc_valid(acc_valid), .acc_bank(acc_bank), .acc_row(acc_row),
      .next_same(next_same), .autopre(autopre), .conflict(conflict),
      .blocked(blocked)
   );

   function automatic int budget(input logic [1:0] c);
      case (c)
         2'b00: return 0;
         2'b01: return 1;
         2'b10: return 3;
         default: return 7;
      endcase
   endfunction

   // expected {blocked, conflict, autopre}
   function automatic logic [2:0] expect_out(input bit v, input bit en, input logic [2:0] b,
                                             input logic [13:0] r, input bit ns, input logic [1:0] c);
      int used;
      bit hit;
      if (!v) return 3'b000;
      if (!en) return 3'b100;
      hit  = m_open[b] && m_row[b] == r;
      used = hit ? m_cnt[b] + 1 : 0;
      return {1'b0, m_open[b] && !hit, (!ns || used >= budget(c))};
   endfunction

   task automatic model_update(input bit v, input bit en, input logic [2:0] b,
                               input logic [13:0] r, input bit ns, input logic [1:0] c);
      int used;
      bit hit;
      if (!en) begin
         for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_cnt[i] = 0; end
      end else if (v) begin
         hit  = m_open[b] && m_row[b] == r;
         used = hit ? m_cnt[b] + 1 : 0;
         if (!ns || used >= budget(c)) begin
            m_open[b] = 0; m_cnt[b] = 0;
         end else begin
            m_open[b] = 1; m_row[b] = r; m_cnt[b] = used;
         end
      end
   endtask

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {blocked,conflict,autopre} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(input string req, input bit v, input bit en, input logic [2:0] b,
                       input logic [13:0] r, input bit ns, input logic [1:0] c);
      logic [2:0] e;
      @(negedge clk);
      acc_valid = v; chan_en = en; acc_bank = b; acc_row = r; next_same = ns; hit_code = c;
      #2;
      e = expect_out(v, en, b, r, ns, c);
      chk(req, {blocked, conflict, autopre}, e);
      model_update(v, en, b, r, ns, c);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_row[i] = '0; m_cnt[i] = 0; end
      rst_n = 1'b0; chan_en = 1'b1; hit_code = 2'b11; acc_valid = 1'b0;
      acc_bank = '0; acc_row = '0; next_same = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R9 reset state
      step("R9 reset idle", 0, 1, 3'd0, 14'd0, 1, 2'b11);
      step("R9 reset closed", 1, 1, 3'd5, 14'd9, 0, 2'b11);

      // R1 budget per code: row closes on access budget+1
      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k <= budget(c[1:0]); k++) begin
            step(c == 0 ? "R2 code00" : "R1 budget", 1, 1, 3'd2, 14'd100, 1, c[1:0]);
            chk("R1 close position", {2'b00, autopre}, {2'b00, k == budget(c[1:0])});
         end
      end

      // R3 no lookahead
      step("R3 open", 1, 1, 3'd4, 14'd7, 1, 2'b11);
      step("R3 no next", 1, 1, 3'd4, 14'd7, 0, 2'b11);
      // R4 bank closed afterwards: different row, no conflict
      step("R4 fresh", 1, 1, 3'd4, 14'd8, 1, 2'b11);

      // R5 conflict then restart count
      step("R5 conflict", 1, 1, 3'd4, 14'd9, 1, 2'b01);
      step("R5 restart hit", 1, 1, 3'd4, 14'd9, 1, 2'b01);

      // R6 independent banks
      step("R6 open b0", 1, 1, 3'd0, 14'd1, 1, 2'b11);
      step("R6 open b1", 1, 1, 3'd1, 14'd1, 1, 2'b11);
      step("R6 hit b0", 1, 1, 3'd0, 14'd1, 1, 2'b11);
      step("R9 idle", 0, 1, 3'd0, 14'd1, 1, 2'b11);
      step("R6 hit b1", 1, 1, 3'd1, 14'd1, 1, 2'b11);

      // R7 disabled, R8 cleared
      step("R7 blocked", 1, 0, 3'd0, 14'd1, 1, 2'b11);
      step("R8 no conflict b1", 1, 1, 3'd1, 14'd2, 1, 2'b11);
      step("R8 no conflict b0", 1, 1, 3'd0, 14'd3, 1, 2'b11);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         step("R1 random", ($urandom % 4) != 0, ($urandom % 16) != 0,
              3'($urandom % 3), 14'($urandom % 3), ($urandom % 5) != 0, 2'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule